// File: doc/BRIEF.md
# Dual-Loop Phase/Frequency Detector with Lock Monitor

This block holds the digital half of the phase comparison for two frequency synthesizer loops, A and B. For each loop it takes a single-cycle pulse from the divided reference and a single-cycle pulse from the divided oscillator feedback. It turns the time between them into up and down enables for an external charge pump. Each loop has a phase-sense setting so that it can serve an oscillator whose frequency rises or falls with tuning voltage. Each loop can also force its pump to high impedance or be powered down. The pump current range is passed through as a level.

Each loop also has a lock detector. It watches the width of every phase-error pulse and raises a lock indicator after a run of narrow comparisons. The indicator dips low while an error pulse is active. One shared monitor pin is driven through a selector. It shows lock for either loop or both, passes through any divider pulse for test, or holds the selected loops' dividers in reset. The interface carries no data stream. Every pin is a plain control or status level, so there is no back-pressure. All inputs are sampled on the rising edge of `clk`. The configuration inputs are expected to be static latched settings.

Top module: `pfd_lock_monitor`

## Requirements
- R1: A reference pulse sets the loop's lead flag and a feedback pulse sets its lag flag. In the cycle when both flags would be set, both clear together. So an error pulse lasts as many cycles as the two pulses are apart, and coincident pulses produce no error pulse.
- R2: With `sense_pos`=1, the lead flag drives `pump_up` and the lag flag drives `pump_dn`. With `sense_pos`=0, the two are swapped.
- R3: `pump_hicur` follows `cur_hi` of the same loop as a plain level (1 = high current range, 0 = low range).
- R4: While `tristate` is 1, `pump_hiz` is 1 and both `pump_up` and `pump_dn` stay 0.
- R5: While `pwrdn` is 1, `pump_hiz` is 1, both flags are held clear so that pulses have no effect, and the lock state is cleared.
- R6: A loop's lock is set after 8 consecutive comparisons in which the error pulse was shorter than 4 cycles.
- R7: A comparison whose error pulse reaches 4 cycles clears the lock at once. A pending error counts as soon as it reaches 4 cycles. A 3-cycle error does not clear the lock.
- R8: `lock_ind` is 1 only while the loop is locked and no error pulse is active. This gives narrow low excursions during each locked comparison.
- R9: These `mon_mode` codes drive `mon_out`: 0 gives constant 0, 1 gives the loop A lock indicator, 2 gives the loop B lock indicator, and 3 gives the AND of both lock indicators.
- R10: These test codes drive `mon_out`: 4 gives the loop A reference pulse, 5 the loop B reference pulse, 6 the loop A feedback pulse and 7 the loop B feedback pulse.
- R11: Code 8 sets `div_hold` to 2'b01, code 9 sets it to 2'b10 and code 10 sets it to 2'b11. In these modes `mon_out` is 0. All other codes give `div_hold`=0, and codes 11 to 15 give `mon_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_pulse | input | 2 | Divided reference pulse, bit 0 loop A, bit 1 loop B |
| div_pulse | input | 2 | Divided feedback pulse per loop |
| sense_pos | input | 2 | Phase sense per loop (1 = positive tuning slope) |
| cur_hi | input | 2 | Pump current range select per loop |
| tristate | input | 2 | Force the pump to high impedance, per loop |
| pwrdn | input | 2 | Power-down per loop |
| mon_mode | input | 4 | Monitor pin selector code |
| pump_up | output | 2 | Source-current enable per loop |
| pump_dn | output | 2 | Sink-current enable per loop |
| pump_hiz | output | 2 | Pump high-impedance control per loop |
| pump_hicur | output | 2 | Pump current range level per loop |
| lock_ind | output | 2 | Lock indicator per loop |
| mon_out | output | 1 | Shared monitor pin |
| div_hold | output | 2 | Hold request for each loop's dividers |

## Verification
A pulse sampled at edge E0 shows on `pump_up` or `pump_dn` after E0. The flags clear at the edge that samples the second pulse. The bench therefore counts the enable cycles at each falling edge across a window that covers both edges, and compares the count with the pulse spacing. The lock state changes at the very edge that closes the deciding comparison, so `lock_ind` is checked at the falling edge after that comparison's idle tail. The monitor, the hold request, the current range and the high-impedance control are combinational from their inputs and from the registered state. They are checked 1 ns after inputs change at a falling edge.

// File: rtl/pfdm_pkg.sv
package pfdm_pkg;
  localparam int LOOPS = 2;

  typedef enum logic [3:0] {
    MON_OFF     = 4'd0,
    MON_LOCK_A  = 4'd1,
    MON_LOCK_B  = 4'd2,
    MON_LOCK_AB = 4'd3,
    MON_REF_A   = 4'd4,
    MON_REF_B   = 4'd5,
    MON_DIV_A   = 4'd6,
    MON_DIV_B   = 4'd7,
    MON_RST_A   = 4'd8,
    MON_RST_B   = 4'd9,
    MON_RST_AB  = 4'd10
  } mon_mode_e;
endpackage

// File: rtl/pfdm_phase_cmp.sv
module pfdm_phase_cmp (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_pulse,
  input  logic div_pulse,
  input  logic sense_pos,
  input  logic hold_tristate,
  input  logic pwrdn,
  output logic pump_up,
  output logic pump_dn,
  output logic pump_hiz,
  output logic err_active,
  output logic cmp_done
);
  logic lead_q, lag_q;
  logic lead_nx, lag_nx, both_set, drive_off;

  assign lead_nx  = lead_q | ref_pulse;
  assign lag_nx   = lag_q | div_pulse;
  assign both_set = lead_nx & lag_nx;
  assign cmp_done = both_set & ~pwrdn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead_q <= 1'b0;
      lag_q  <= 1'b0;
    end else if (pwrdn || both_set) begin
      lead_q <= 1'b0;
      lag_q  <= 1'b0;
    end else begin
      lead_q <= lead_nx;
      lag_q  <= lag_nx;
    end
  end

  assign err_active = lead_q | lag_q;
  assign drive_off  = hold_tristate | pwrdn;
  assign pump_hiz   = drive_off;
  assign pump_up    = ~drive_off & (sense_pos ? lead_q : lag_q);
  assign pump_dn    = ~drive_off & (sense_pos ? lag_q : lead_q);

  // R1: flags never both set after an edge
  a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_q && lag_q));
  // R1: a lone reference pulse sets the lead flag
  a_r1_lead_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pulse && !div_pulse && !lag_q && !pwrdn) |=> lead_q);
  // R5: power-down clears the comparator
  a_r5_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    pwrdn |=> (!lead_q && !lag_q));
  // R4: no drive while released
  a_r4_hiz_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    pump_hiz |-> (!pump_up && !pump_dn));
endmodule

// File: rtl/pfdm_lock_det.sv
module pfdm_lock_det #(
  parameter int WIN  = 4,
  parameter int NEED = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic err_active,
  input  logic cmp_done,
  input  logic pwrdn,
  output logic lock_ind
);
  localparam int CW = $clog2(WIN + 1);
  localparam int GW = $clog2(NEED + 1);

  logic [CW-1:0] err_q;
  logic [GW-1:0] good_q;
  logic [CW:0]   width_now;
  logic          bad_evt, good_evt, locked;

  assign width_now = {1'b0, err_q} + {{CW{1'b0}}, err_active};
  assign bad_evt   = err_active && (err_q == CW'(WIN - 1));
  assign good_evt  = cmp_done && (width_now < (CW+1)'(WIN));
  assign locked    = (good_q == GW'(NEED));
  assign lock_ind  = locked & ~err_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
    end else if (pwrdn || cmp_done) begin
      err_q <= '0;
    end else if (err_active && err_q != CW'(WIN)) begin
      err_q <= err_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_q <= '0;
    end else if (pwrdn || bad_evt) begin
      good_q <= '0;
    end else if (good_evt && !locked) begin
      good_q <= good_q + 1'b1;
    end
  end

  // R7: a wide error drops lock at the next edge
  a_r7_drop_on_wide: assert property (@(posedge clk) disable iff (!rst_n)
    bad_evt |=> !locked);
  // R6: lock only rises on a narrow comparison
  a_r6_rise_on_good: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(good_evt));
  // R5: power-down leaves the loop unlocked
  a_r5_pd_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    pwrdn |=> !locked);
endmodule

// File: rtl/pfdm_mon_sel.sv
module pfdm_mon_sel
  import pfdm_pkg::*;
(
  input  logic [3:0]       mode,
  input  logic [LOOPS-1:0] lock_ind,
  input  logic [LOOPS-1:0] ref_pulse,
  input  logic [LOOPS-1:0] div_pulse,
  output logic             mon_out,
  output logic [LOOPS-1:0] div_hold
);
  mon_mode_e m;
  assign m = mon_mode_e'(mode);

  always_comb begin
    mon_out  = 1'b0;
    div_hold = '0;
    case (m)
      MON_LOCK_A:  mon_out = lock_ind[0];
      MON_LOCK_B:  mon_out = lock_ind[1];
      MON_LOCK_AB: mon_out = lock_ind[0] & lock_ind[1];
      MON_REF_A:   mon_out = ref_pulse[0];
      MON_REF_B:   mon_out = ref_pulse[1];
      MON_DIV_A:   mon_out = div_pulse[0];
      MON_DIV_B:   mon_out = div_pulse[1];
      MON_RST_A:   div_hold = 2'b01;
      MON_RST_B:   div_hold = 2'b10;
      MON_RST_AB:  div_hold = 2'b11;
      default:     mon_out = 1'b0;
    endcase
  end
endmodule

// File: rtl/pfd_lock_monitor.sv
module pfd_lock_monitor
  import pfdm_pkg::*;
#(
  parameter int LOCK_WIN  = 4,
  parameter int LOCK_NEED = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ref_pulse,
  input  logic [1:0] div_pulse,
  input  logic [1:0] sense_pos,
  input  logic [1:0] cur_hi,
  input  logic [1:0] tristate,
  input  logic [1:0] pwrdn,
  input  logic [3:0] mon_mode,
  output logic [1:0] pump_up,
  output logic [1:0] pump_dn,
  output logic [1:0] pump_hiz,
  output logic [1:0] pump_hicur,
  output logic [1:0] lock_ind,
  output logic       mon_out,
  output logic [1:0] div_hold
);
  logic [LOOPS-1:0] err_active, cmp_done;

  for (genvar g = 0; g < LOOPS; g++) begin : g_loop
    pfdm_phase_cmp u_cmp (
      .clk          (clk),
      .rst_n        (rst_n),
      .ref_pulse    (ref_pulse[g]),
      .div_pulse    (div_pulse[g]),
      .sense_pos    (sense_pos[g]),
      .hold_tristate(tristate[g]),
      .pwrdn        (pwrdn[g]),
      .pump_up      (pump_up[g]),
      .pump_dn      (pump_dn[g]),
      .pump_hiz     (pump_hiz[g]),
      .err_active   (err_active[g]),
      .cmp_done     (cmp_done[g])
    );

    pfdm_lock_det #(.WIN(LOCK_WIN), .NEED(LOCK_NEED)) u_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .err_active(err_active[g]),
      .cmp_done  (cmp_done[g]),
      .pwrdn     (pwrdn[g]),
      .lock_ind  (lock_ind[g])
    );
  end

  assign pump_hicur = cur_hi;

  pfdm_mon_sel u_mon (
    .mode     (mon_mode),
    .lock_ind (lock_ind),
    .ref_pulse(ref_pulse),
    .div_pulse(div_pulse),
    .mon_out  (mon_out),
    .div_hold (div_hold)
  );

  // R8: indicator low while an error pulse is active
  a_r8_dip_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_up[0] || pump_dn[0]) |-> !lock_ind[0]);
  // R9: combined lock needs both loops
  a_r9_both_needs_two: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_mode == 4'd3 && mon_out) |-> (lock_ind[0] && lock_ind[1]));
  // R11: hold modes keep the pin low
  a_r11_hold_pin_low: assert property (@(posedge clk) disable iff (!rst_n)
    (div_hold != 2'b00) |-> !mon_out);
endmodule

// File: tb/test_pfd_lock_monitor.sv
`timescale 1ns/1ps
module test_pfd_lock_monitor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] ref_pulse = '0, div_pulse = '0, sense_pos = 2'b11;
  logic [1:0] cur_hi = '0, tristate = '0, pwrdn = '0;
  logic [3:0] mon_mode = '0;
  logic [1:0] pump_up, pump_dn, pump_hiz, pump_hicur, lock_ind, div_hold;
  logic       mon_out;

  int n_chk = 0, n_fail = 0, sum_up = 0, sum_dn = 0;

  always #2.5 clk = ~clk;

  pfd_lock_monitor i_pfd_lock_monitor (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .div_pulse(div_pulse),
    .sense_pos(sense_pos), .cur_hi(cur_hi), .tristate(tristate), .pwrdn(pwrdn),
    .mon_mode(mon_mode), .pump_up(pump_up), .pump_dn(pump_dn),
    .pump_hiz(pump_hiz), .pump_hicur(pump_hicur), .lock_ind(lock_ind),
    .mon_out(mon_out), .div_hold(div_hold)
  );

  typedef struct packed {
    logic       sense;
    logic       ref_first;
    logic [3:0] gap;
    logic [3:0] exp_up;
    logic [3:0] exp_dn;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{1'b1, 1'b1, 4'd2, 4'd2, 4'd0},
    '{1'b1, 1'b0, 4'd3, 4'd0, 4'd3},
    '{1'b0, 1'b1, 4'd2, 4'd0, 4'd2},
    '{1'b0, 1'b0, 4'd1, 4'd1, 4'd0},
    '{1'b1, 1'b1, 4'd0, 4'd0, 4'd0},
    '{1'b1, 1'b1, 4'd5, 4'd5, 4'd0},
    '{1'b0, 1'b0, 4'd5, 4'd5, 4'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int lp, input bit r, input bit d);
    @(negedge clk);
    sum_up += int'(pump_up[lp]);
    sum_dn += int'(pump_dn[lp]);
    ref_pulse = '0;
    div_pulse = '0;
    ref_pulse[lp] = r;
    div_pulse[lp] = d;
  endtask

  task automatic pair(input int lp, input bit ref_first, input int gap);
    sum_up = 0;
    sum_dn = 0;
    if (gap == 0) step(lp, 1'b1, 1'b1);
    else begin
      step(lp, ref_first, !ref_first);
      repeat (gap - 1) step(lp, 1'b0, 1'b0);
      step(lp, !ref_first, ref_first);
    end
    repeat (4) step(lp, 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset up", int'(pump_up), 0);
    chk("R1 reset dn", int'(pump_dn), 0);
    chk("R6 reset lock", int'(lock_ind), 0);
    chk("R9 reset mon", int'(mon_out), 0);

    // R1 R2: pulse spacing and sense table on loop B
    for (int i = 0; i < 7; i++) begin
      sense_pos[1] = VEC[i].sense;
      pair(1, VEC[i].ref_first, int'(VEC[i].gap));
      chk("R1/R2 up cycles", sum_up, int'(VEC[i].exp_up));
      chk("R1/R2 dn cycles", sum_dn, int'(VEC[i].exp_dn));
    end

    // R3
    cur_hi = 2'b01; #1 chk("R3 range", int'(pump_hicur), 1);
    cur_hi = 2'b10; #1 chk("R3 range", int'(pump_hicur), 2);

    // R6: lock on the eighth narrow comparison
    for (int i = 0; i < 7; i++) pair(0, 1'b1, 1);
    chk("R6 not yet locked", int'(lock_ind[0]), 0);
    pair(0, 1'b1, 1);
    chk("R6 locked", int'(lock_ind[0]), 1);

    // R8: dip while the error pulse runs
    step(0, 1'b1, 1'b0);
    step(0, 1'b0, 1'b0);
    chk("R8 dip", int'(lock_ind[0]), 0);
    step(0, 1'b0, 1'b1);
    repeat (3) step(0, 1'b0, 1'b0);
    chk("R8 back high", int'(lock_ind[0]), 1);

    // R7: boundary widths
    pair(0, 1'b1, 3);
    chk("R7 width 3 keeps lock", int'(lock_ind[0]), 1);
    pair(0, 1'b1, 4);
    chk("R7 width 4 drops lock", int'(lock_ind[0]), 0);

    for (int i = 0; i < 8; i++) pair(0, 1'b1, 1);
    chk("R6 relock", int'(lock_ind[0]), 1);

    // R9: loop A locked, loop B not
    mon_mode = 4'd1; #1 chk("R9 lock A", int'(mon_out), 1);
    mon_mode = 4'd2; #1 chk("R9 lock B", int'(mon_out), 0);
    mon_mode = 4'd3; #1 chk("R9 both one locked", int'(mon_out), 0);
    mon_mode = 4'd0; #1 chk("R9 off", int'(mon_out), 0);
    for (int i = 0; i < 8; i++) pair(1, 1'b1, 1);
    mon_mode = 4'd3; #1 chk("R9 both locked", int'(mon_out), 1);

    // R10: divider pass-through
    @(negedge clk);
    mon_mode = 4'd4; ref_pulse = 2'b01; #1 chk("R10 ref A", int'(mon_out), 1);
    ref_pulse = 2'b00; #1 chk("R10 ref A low", int'(mon_out), 0);
    mon_mode = 4'd7; div_pulse = 2'b10; #1 chk("R10 div B", int'(mon_out), 1);
    mon_mode = 4'd6; #1 chk("R10 div A", int'(mon_out), 0);
    div_pulse = 2'b00;

    // R11: hold modes
    mon_mode = 4'd10; #1 chk("R11 hold both", int'(div_hold), 3);
    chk("R11 pin low", int'(mon_out), 0);
    mon_mode = 4'd8; #1 chk("R11 hold A", int'(div_hold), 1);
    mon_mode = 4'd9; #1 chk("R11 hold B", int'(div_hold), 2);
    mon_mode = 4'd0; #1 chk("R11 no hold", int'(div_hold), 0);
    repeat (4) step(0, 1'b0, 1'b0);

    // R4: forced release
    tristate[0] = 1'b1;
    step(0, 1'b1, 1'b0);
    step(0, 1'b0, 1'b0);
    chk("R4 no up drive", int'(pump_up[0]), 0);
    chk("R4 hiz", int'(pump_hiz[0]), 1);
    step(0, 1'b0, 1'b1);
    repeat (3) step(0, 1'b0, 1'b0);
    tristate[0] = 1'b0;
    #1 chk("R4 released", int'(pump_hiz[0]), 0);

    // R5: power-down
    for (int i = 0; i < 8; i++) pair(0, 1'b1, 1);
    chk("R5 locked before", int'(lock_ind[0]), 1);
    pwrdn[0] = 1'b1;
    step(0, 1'b0, 1'b0);
    step(0, 1'b0, 1'b0);
    chk("R5 lock cleared", int'(lock_ind[0]), 0);
    chk("R5 hiz", int'(pump_hiz[0]), 1);
    step(0, 1'b1, 1'b0);
    step(0, 1'b0, 1'b0);
    pwrdn[0] = 1'b0;
    step(0, 1'b0, 1'b0);
    step(0, 1'b0, 1'b0);
    chk("R5 pulse ignored", int'(pump_up[0]), 0);
    chk("R5 still unlocked", int'(lock_ind[0]), 0);

    finish_run();
  end
endmodule